// File: doc/BRIEF.md
# Video-Priority VRAM Bus Arbiter

This block decides, clock by clock, who drives a single 16 KB video RAM. One side is a display fetch engine. The other is an 8-bit CPU whose bus reaches the RAM through external octal transceivers. The display engine always wins when it asks. The CPU is served only while the raster is in horizontal or vertical blanking and the display engine is idle. A CPU access that hits the VRAM window at any other time is stalled: the ready line is pulled low and the transceivers stay disabled until a grant arrives.

Ownership is held in a register and changes only on a clock edge. The choice for a cycle is made from the requests and blanking flags seen in the cycle before it. As a result, a CPU cycle that has already been granted always runs to its end, even if blanking stops partway through. A display request that shows up in that same cycle is served one cycle later. The RAM address comes either from the CPU offset or from the display address, and never from both. The RAM strobes stay inactive when no side is accessing. Data moves through the external transceivers, so this block carries control and address only.

Top module: `vram_arbiter`

## Requirements
- R1: While rst_n is low, ram_cs_n, ram_oe_n, ram_we_n and buf_oe_n are 1, disp_gnt is 0, and cpu_rdy is 1 when there is no CPU cycle.
- R2: A CPU cycle hits the window only when cpu_cyc is 1 and cpu_addr[15:14] equals WIN_BASE. The default of 2 covers 0x8000 to 0xBFFF. A cycle outside the window leaves cpu_rdy at 1 and causes no RAM access.
- R3: During a window hit, cpu_rdy is 0 and buf_oe_n is 1 unless the CPU holds the grant. The CPU can hold the grant only if hblank or vblank was 1 in the previous cycle.
- R4: The CPU holds the grant in a cycle if, in the previous cycle, there was a window hit, hblank or vblank was 1, and disp_req was 0. During a granted hit, cpu_rdy is 1, buf_oe_n is 0, and ram_cs_n is 0. ram_addr equals cpu_addr[13:0]. When cpu_we is 1, ram_we_n is 0 and ram_oe_n is 1. When cpu_we is 0 (a read), ram_oe_n is 0 and ram_we_n is 1.
- R5: If disp_req was 1 in the previous cycle, the display holds the grant, even during blanking and even when a CPU hit is pending.
- R6: While the display holds the grant, disp_gnt is 1, ram_addr equals disp_addr, ram_oe_n is 0, ram_we_n is 1, and ram_cs_n is 0.
- R7: A CPU grant is never cut short. If blanking ends and disp_req rises in a granted cycle, that cycle still completes with cpu_rdy 1 and disp_gnt 0. The display is granted in the next cycle.
- R8: When no side holds an active access, ram_cs_n, ram_oe_n and ram_we_n are 1 and buf_oe_n is 1.
- R9: ram_we_n is 0 only in a cycle where cpu_rdy is 1 and buf_oe_n is 0, so no RAM write happens during a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address bus |
| cpu_cyc | input | 1 | CPU bus cycle valid |
| cpu_we | input | 1 | CPU cycle is a write (1) or read (0) |
| hblank | input | 1 | Horizontal blanking flag |
| vblank | input | 1 | Vertical blanking flag |
| disp_req | input | 1 | Display fetch engine wants the RAM |
| disp_addr | input | 14 | Display fetch address |
| disp_gnt | output | 1 | Display holds the RAM this cycle |
| cpu_rdy | output | 1 | CPU ready, low to stall |
| buf_oe_n | output | 1 | Transceiver output enable, active low |
| ram_addr | output | 14 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
The interesting collision is a granted CPU cycle landing in the same cycle as two other events: the end of blanking and the rise of a display request. The bench builds this on purpose. It opens a grant during horizontal blanking, then drops hblank and raises disp_req in one drive step. It then expects ready high with no display grant for that cycle, followed by a display grant with ready low in the next. A long pseudo-random run then throws blanking edges, display requests and window hits at the block together. A behavioural ownership model in the bench judges every clock.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_CPU  = 2'd1,
      OWN_DISP = 2'd2
   } owner_e;

endpackage

// File: rtl/vram_win_decode.sv
module vram_win_decode #(
   parameter int unsigned CPU_AW   = 16,
   parameter int unsigned RAM_AW   = 14,
   parameter int unsigned WIN_BASE = 2
) (
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              cpu_cyc,
   output logic              win_hit,
   output logic [RAM_AW-1:0] win_off
);
   localparam int unsigned TAG_W = CPU_AW - RAM_AW;

   generate
      if (CPU_AW < RAM_AW) begin : g_bad_width
         $error("vram_win_decode: CPU address narrower than RAM address");
      end
      if (TAG_W == 0) begin : g_full_map
         assign win_hit = cpu_cyc;
      end else begin : g_tag_cmp
         if (WIN_BASE >= (1 << TAG_W)) begin : g_bad_base
            $error("vram_win_decode: WIN_BASE does not fit the tag bits");
         end
         logic [TAG_W-1:0] tag;
         assign tag     = cpu_addr[CPU_AW-1:RAM_AW];
         assign win_hit = cpu_cyc && (tag == TAG_W'(WIN_BASE));
      end
   endgenerate

   assign win_off = cpu_addr[RAM_AW-1:0];

endmodule

// File: rtl/vram_owner_fsm.sv
module vram_owner_fsm
   import vram_arb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   win_hit,
   input  logic   blank_any,
   input  logic   disp_req,
   output owner_e owner_q
);
   owner_e owner_d;

   // Display first; CPU only in blanking. The choice is registered, so a
   // granted CPU cycle always finishes before the display takes over.
   always_comb begin
      if (disp_req) begin
         owner_d = OWN_DISP;
      end else if (win_hit && blank_any) begin
         owner_d = OWN_CPU;
      end else begin
         owner_d = OWN_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_IDLE;
      end else begin
         owner_q <= owner_d;
      end
   end

endmodule

// File: rtl/vram_port_mux.sv
module vram_port_mux
   import vram_arb_pkg::*;
#(
   parameter int unsigned RAM_AW = 14
) (
   input  owner_e            owner_q,
   input  logic              win_hit,
   input  logic              cpu_we,
   input  logic [RAM_AW-1:0] win_off,
   input  logic [RAM_AW-1:0] disp_addr,
   output logic              disp_gnt,
   output logic              cpu_rdy,
   output logic              buf_oe_n,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_cs_n,
   output logic              ram_oe_n,
   output logic              ram_we_n
);
   logic cpu_act;
   logic disp_act;

   assign cpu_act  = (owner_q == OWN_CPU) && win_hit;
   assign disp_act = (owner_q == OWN_DISP);

   assign disp_gnt = disp_act;
   assign cpu_rdy  = !win_hit || (owner_q == OWN_CPU);
   assign buf_oe_n = !cpu_act;
   assign ram_addr = cpu_act ? win_off : disp_addr;
   assign ram_cs_n = !(cpu_act || disp_act);
   assign ram_we_n = !(cpu_act && cpu_we);
   assign ram_oe_n = !(disp_act || (cpu_act && !cpu_we));

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
   import vram_arb_pkg::*;
#(
   parameter int unsigned CPU_AW   = 16,
   parameter int unsigned RAM_AW   = 14,
   parameter int unsigned WIN_BASE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              cpu_cyc,
   input  logic              cpu_we,
   input  logic              hblank,
   input  logic              vblank,
   input  logic              disp_req,
   input  logic [RAM_AW-1:0] disp_addr,
   output logic              disp_gnt,
   output logic              cpu_rdy,
   output logic              buf_oe_n,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_cs_n,
   output logic              ram_oe_n,
   output logic              ram_we_n
);
   logic              win_hit;
   logic [RAM_AW-1:0] win_off;
   logic              blank_any;
   owner_e            owner_q;

   assign blank_any = hblank || vblank;

   vram_win_decode #(
      .CPU_AW   (CPU_AW),
      .RAM_AW   (RAM_AW),
      .WIN_BASE (WIN_BASE)
   ) u_dec (
      .cpu_addr (cpu_addr),
      .cpu_cyc  (cpu_cyc),
      .win_hit  (win_hit),
      .win_off  (win_off)
   );

   vram_owner_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_hit   (win_hit),
      .blank_any (blank_any),
      .disp_req  (disp_req),
      .owner_q   (owner_q)
   );

   vram_port_mux #(
      .RAM_AW (RAM_AW)
   ) u_mux (
      .owner_q   (owner_q),
      .win_hit   (win_hit),
      .cpu_we    (cpu_we),
      .win_off   (win_off),
      .disp_addr (disp_addr),
      .disp_gnt  (disp_gnt),
      .cpu_rdy   (cpu_rdy),
      .buf_oe_n  (buf_oe_n),
      .ram_addr  (ram_addr),
      .ram_cs_n  (ram_cs_n),
      .ram_oe_n  (ram_oe_n),
      .ram_we_n  (ram_we_n)
   );

endmodule

// File: rtl/vram_arbiter_chk.sv
module vram_arbiter_chk #(
   parameter int unsigned RAM_AW = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              win_hit,
   input logic              blank_any,
   input logic              disp_req,
   input logic [RAM_AW-1:0] disp_addr,
   input logic              disp_gnt,
   input logic              cpu_rdy,
   input logic              buf_oe_n,
   input logic [RAM_AW-1:0] ram_addr,
   input logic              ram_cs_n,
   input logic              ram_oe_n,
   input logic              ram_we_n
);
   logic prev_blank;
   logic prev_disp_req;
   logic prev_cpu_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_blank    <= 1'b0;
         prev_disp_req <= 1'b0;
         prev_cpu_ok   <= 1'b0;
      end else begin
         prev_blank    <= blank_any;
         prev_disp_req <= disp_req;
         prev_cpu_ok   <= win_hit && blank_any && !disp_req;
      end
   end

   assert_outside_rdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_hit |-> cpu_rdy);

   assert_stall_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && !prev_blank) |-> !cpu_rdy);

   assert_stall_buf_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rdy |-> buf_oe_n);

   assert_cpu_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      prev_cpu_ok |-> cpu_rdy);

   assert_disp_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prev_disp_req |-> (disp_gnt && buf_oe_n));

   assert_disp_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
      disp_gnt |-> (ram_addr == disp_addr && !ram_oe_n && ram_we_n && !ram_cs_n));

   assert_no_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
      prev_cpu_ok |-> !disp_gnt);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_cs_n |-> (ram_we_n && ram_oe_n && buf_oe_n));

   assert_no_stall_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (cpu_rdy && !buf_oe_n));

endmodule

bind vram_arbiter vram_arbiter_chk #(.RAM_AW(RAM_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .win_hit   (win_hit),
   .blank_any (blank_any),
   .disp_req  (disp_req),
   .disp_addr (disp_addr),
   .disp_gnt  (disp_gnt),
   .cpu_rdy   (cpu_rdy),
   .buf_oe_n  (buf_oe_n),
   .ram_addr  (ram_addr),
   .ram_cs_n  (ram_cs_n),
   .ram_oe_n  (ram_oe_n),
   .ram_we_n  (ram_we_n)
);

// File: tb/vram_arbiter_tb.sv
`timescale 1ns/100ps
module vram_arbiter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_cyc = 1'b0;
   logic        cpu_we = 1'b0;
   logic        hblank = 1'b0;
   logic        vblank = 1'b0;
   logic        disp_req = 1'b0;
   logic [13:0] disp_addr = '0;
   logic        disp_gnt, cpu_rdy, buf_oe_n, ram_cs_n, ram_oe_n, ram_we_n;
   logic [13:0] ram_addr;

   int total = 0;
   int bad   = 0;
   bit mon_en = 1'b0;
   bit done   = 1'b0;
   int m_own  = 0;   // 0 none, 1 cpu, 2 display

   always #2.5 clk = ~clk;

   vram_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_cyc(cpu_cyc),
      .cpu_we(cpu_we), .hblank(hblank), .vblank(vblank), .disp_req(disp_req),
      .disp_addr(disp_addr), .disp_gnt(disp_gnt), .cpu_rdy(cpu_rdy),
      .buf_oe_n(buf_oe_n), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n),
      .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit in_win();
      return cpu_cyc && (cpu_addr >= 16'h8000) && (cpu_addr < 16'hC000);
   endfunction

   // behavioural ownership model: decided at each edge from the cycle before
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_own <= 0;
      else if (disp_req) m_own <= 2;
      else if (in_win() && (hblank || vblank)) m_own <= 1;
      else m_own <= 0;
   end

   // per-clock comparison, sampled late in the cycle
   always @(posedge clk) begin
      #4;
      if (mon_en) begin
         bit hit, cact;
         hit  = in_win();
         cact = (m_own == 1) && hit;
         chk("R3", "cpu_rdy", cpu_rdy, (!hit || m_own == 1) ? 1 : 0);
         chk("R3", "buf_oe_n", buf_oe_n, cact ? 0 : 1);
         chk("R9", "ram_we_n", ram_we_n, (cact && cpu_we) ? 0 : 1);
         chk("R4", "ram_oe_n", ram_oe_n, (m_own == 2 || (cact && !cpu_we)) ? 0 : 1);
         chk("R8", "ram_cs_n", ram_cs_n, (m_own == 2 || cact) ? 0 : 1);
         chk("R5", "disp_gnt", disp_gnt, (m_own == 2) ? 1 : 0);
         chk("R6", "ram_addr", ram_addr, cact ? int'(cpu_addr[13:0]) : int'(disp_addr));
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      logic [15:0] lfsr;
      #3;
      // R1 reset state
      chk("R1", "ram_cs_n", ram_cs_n, 1);
      chk("R1", "ram_oe_n", ram_oe_n, 1);
      chk("R1", "ram_we_n", ram_we_n, 1);
      chk("R1", "buf_oe_n", buf_oe_n, 1);
      chk("R1", "disp_gnt", disp_gnt, 0);
      chk("R1", "cpu_rdy", cpu_rdy, 1);
      step(); step();
      rst_n = 1'b1;
      step();
      mon_en = 1'b1;

      // R2 access outside the window
      cpu_cyc = 1; cpu_addr = 16'h1234; cpu_we = 1;
      #3; chk("R2", "cpu_rdy outside", cpu_rdy, 1);
      step(); #3; chk("R2", "ram_cs_n outside", ram_cs_n, 1);
      chk("R2", "ram_we_n outside", ram_we_n, 1);

      // R3 window hit in active video
      step(); cpu_addr = 16'h8005;
      #3; chk("R3", "cpu_rdy stall", cpu_rdy, 0);
      chk("R3", "buf_oe_n stall", buf_oe_n, 1);
      step(); #3; chk("R3", "cpu_rdy stall held", cpu_rdy, 0);
      chk("R9", "ram_we_n stall", ram_we_n, 1);

      // R4 grant after blanking begins
      step(); hblank = 1;
      #3; chk("R3", "cpu_rdy first blank cycle", cpu_rdy, 0);
      step(); #3;
      chk("R4", "cpu_rdy granted", cpu_rdy, 1);
      chk("R4", "buf_oe_n granted", buf_oe_n, 0);
      chk("R4", "ram_we_n write", ram_we_n, 0);
      chk("R4", "ram_addr cpu", ram_addr, 14'h0005);

      // R7 blanking ends and display asks in the granted cycle
      step(); hblank = 0; disp_req = 1; disp_addr = 14'h0ABC;
      #3; chk("R7", "cpu_rdy kept", cpu_rdy, 1);
      chk("R7", "disp_gnt waits", disp_gnt, 0);
      step(); #3;
      chk("R7", "disp_gnt next", disp_gnt, 1);
      chk("R7", "cpu_rdy after", cpu_rdy, 0);
      chk("R6", "ram_addr disp", ram_addr, 14'h0ABC);
      chk("R6", "ram_oe_n disp", ram_oe_n, 0);

      // R5 display wins inside blanking
      step(); hblank = 1;
      step(); #3;
      chk("R5", "disp_gnt in blank", disp_gnt, 1);
      chk("R5", "cpu_rdy in blank", cpu_rdy, 0);
      chk("R9", "ram_we_n no write", ram_we_n, 1);

      // R8 nobody accessing
      step(); cpu_cyc = 0; disp_req = 0; hblank = 0;
      step(); #3;
      chk("R8", "ram_cs_n idle", ram_cs_n, 1);
      chk("R8", "ram_oe_n idle", ram_oe_n, 1);
      chk("R8", "ram_we_n idle", ram_we_n, 1);
      chk("R8", "buf_oe_n idle", buf_oe_n, 1);

      // R4 read at top of window during vertical blanking
      step(); cpu_cyc = 1; cpu_we = 0; cpu_addr = 16'hBFFF; vblank = 1;
      step(); #3;
      chk("R4", "cpu_rdy read", cpu_rdy, 1);
      chk("R4", "ram_oe_n read", ram_oe_n, 0);
      chk("R4", "ram_we_n read", ram_we_n, 1);
      chk("R4", "ram_addr read", ram_addr, 14'h3FFF);

      // R2 first address past the window
      step(); cpu_addr = 16'hC000;
      #3; chk("R2", "cpu_rdy past window", cpu_rdy, 1);
      step(); #3; chk("R2", "ram_cs_n past window", ram_cs_n, 1);

      // mixed traffic judged by the model
      lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         step();
         for (int k = 0; k < 16; k++)
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cpu_cyc   = lfsr[0] | lfsr[1];
         cpu_we    = lfsr[2];
         cpu_addr  = {lfsr[15:14], lfsr[13:0] ^ 14'(i)};
         hblank    = lfsr[3] & lfsr[4];
         vblank    = lfsr[5] & lfsr[6] & lfsr[7];
         disp_req  = lfsr[8] & lfsr[9];
         disp_addr = 14'(i * 7);
      end
      step(); step();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule